// File: doc/BRIEF.md
# Immediate-Operand Execute Unit with Status Flags

This block is the execute stage for the immediate-operand class of a small 8-bit processor. Each cycle it may accept one fetched 16-bit instruction word. The upper byte of the word selects the operation and the lower byte is the 8-bit immediate. The block holds the architectural state that these operations touch:

- an 8-bit working register (W);
- a 4-bit bank register;
- a 16-bit product register;
- three 12-bit indirect pointers;
- a five-bit status register.

The arithmetic operations are add and subtract-from-immediate. Subtraction computes the immediate minus W. The logic operations are AND, inclusive OR and exclusive OR. The remaining operations are move-to-W, unsigned multiply, bank load and return-with-immediate. Each operation changes only the flags that belong to its class.

A pointer load uses two words. The first word carries the pointer number and the high four bits of the 12-bit value. The following accepted word carries the low byte. When the second-word prefix arrives without a pending first word, it does nothing.

A return changes the program counter. So the block pulses `ret_strobe` while the return word is presented, and then raises `stall` for one cycle. Any word offered during the stall cycle is discarded. The status register is laid out as bit 4 N, bit 3 OV, bit 2 Z, bit 1 DC, bit 0 C. All state outputs are registered and update on the clock edge at which a word is accepted.

Top module: `lit_exec_unit`

## Requirements
- R1: After reset, W, bank, product, all pointers and status read zero, and `stall` is low. A word is accepted on a rising edge when `instr_valid` is high and `stall` is low. With `instr_valid` low, no state changes.
- R2: Upper byte 0x0F adds the immediate to W and writes the sum to W. C is the carry out of bit 7, DC is the carry out of bit 3, Z marks a zero result, OV marks signed overflow and N is result bit 7.
- R3: Upper byte 0x08 writes immediate minus W to W. C is set when there is no borrow (immediate >= W) and DC is set when there is no borrow from bit 3. OV marks signed overflow of the 8-bit result. Z and N follow the result.
- R4: Upper bytes 0x0B, 0x09 and 0x0A write W AND, OR or XOR the immediate to W. They update only Z and N, and C, DC and OV hold their values.
- R5: Upper byte 0x0E loads the immediate into W and leaves the status register unchanged.
- R6: Upper byte 0x0D writes the unsigned 8x8 product of W and the immediate to the product register. W and the status register are unchanged.
- R7: Upper byte 0x01 with word bits 7:4 equal to zero loads word bits 3:0 into the bank register. With any of bits 7:4 set, the word is a no-op.
- R8: First word 0xEE with bits 7:6 zero selects the pointer with bits 5:4 and gives value bits 11:8 in bits 3:0. If the next accepted word has upper byte 0xF0, its low byte completes the 12-bit value and the selected pointer is written. If the next accepted word is anything else, the load is abandoned and that word runs normally. A pointer load leaves the status register unchanged.
- R9: A word with upper byte 0xF0 that is not preceded by a pending first word changes no state.
- R10: Pointer number 3 is reserved, and a completed load that selects it leaves all pointers unchanged.
- R11: Upper byte 0x0C loads the immediate into W, raises `ret_strobe` in the cycle the word is presented and raises `stall` for exactly the next cycle. A word presented during that stall cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | A fetched word is present this cycle |
| instr_word | input | 16 | Instruction word: opcode byte above, immediate below |
| w_q | output | 8 | Working register |
| bank_q | output | 4 | Bank register |
| prod_q | output | 16 | Product register |
| ptr_flat | output | 36 | Pointers; pointer n at bits 12n+11:12n |
| status_q | output | 5 | {N, OV, Z, DC, C} |
| stall | output | 1 | Flush cycle following a return |
| ret_strobe | output | 1 | Return word is being accepted this cycle |

## Verification
Addition is tried with operands that overflow into the sign bit and with operands that wrap to zero. These two cases tell the C flag apart from OV and separate DC from C. Subtraction is tried with a borrow, a borrow only in the low nibble, an equal pair and a signed overflow. This shows that the operand order is immediate minus W and that C means no borrow. The logic operations start from a status value with C and OV set, so any write to a flag outside Z and N shows up. The pointer tests cover a normal load and a load with the pointer number in the high bits, as well as a reserved select, an orphan second word and an abandoned first word.

// File: rtl/lit_alu_pkg.sv
package lit_alu_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR,
    OP_MOV, OP_MUL, OP_RET, OP_BANK, OP_PTRHI, OP_PTRLO
  } lit_op_e;

  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic dc;
    logic c;
  } flags_t;
endpackage

// File: rtl/lit_decode.sv
module lit_decode
  import lit_alu_pkg::*;
(
  input  logic [15:0] word,
  output lit_op_e     op,
  output logic [7:0]  imm
);
  logic [7:0] opc;
  assign opc = word[15:8];
  assign imm = word[7:0];

  always_comb begin
    case (opc)
      8'h0F:   op = OP_ADD;
      8'h08:   op = OP_SUB;
      8'h0B:   op = OP_AND;
      8'h09:   op = OP_IOR;
      8'h0A:   op = OP_XOR;
      8'h0E:   op = OP_MOV;
      8'h0D:   op = OP_MUL;
      8'h0C:   op = OP_RET;
      8'h01:   op = (imm[7:4] == 4'h0) ? OP_BANK : OP_NONE;
      8'hEE:   op = (imm[7:6] == 2'b00) ? OP_PTRHI : OP_NONE;
      8'hF0:   op = OP_PTRLO;
      default: op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/lit_arith.sv
module lit_arith
  import lit_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  lit_op_e         op,
  input  logic [DW-1:0]   w_in,
  input  logic [DW-1:0]   imm,
  input  flags_t          flg_in,
  output logic [DW-1:0]   w_out,
  output logic            w_wr,
  output flags_t          flg_out,
  output logic [2*DW-1:0] product
);
  localparam int NIB = DW / 2;

  logic [DW:0]   add_full, sub_full;
  logic [NIB:0]  add_nib, sub_nib;
  logic [DW-1:0] logic_res;

  // Subtraction runs as imm + ~W + 1 so both carries read "no borrow".
  assign add_full = {1'b0, w_in} + {1'b0, imm};
  assign sub_full = {1'b0, imm} + {1'b0, ~w_in} + {{DW{1'b0}}, 1'b1};
  assign add_nib  = {1'b0, w_in[NIB-1:0]} + {1'b0, imm[NIB-1:0]};
  assign sub_nib  = {1'b0, imm[NIB-1:0]} + {1'b0, ~w_in[NIB-1:0]} + {{NIB{1'b0}}, 1'b1};
  assign product  = w_in * imm;

  always_comb begin
    case (op)
      OP_AND:  logic_res = w_in & imm;
      OP_IOR:  logic_res = w_in | imm;
      default: logic_res = w_in ^ imm;
    endcase
  end

  always_comb begin
    w_out   = w_in;
    w_wr    = 1'b0;
    flg_out = flg_in;
    case (op)
      OP_ADD: begin
        w_out      = add_full[DW-1:0];
        w_wr       = 1'b1;
        flg_out.c  = add_full[DW];
        flg_out.dc = add_nib[NIB];
        flg_out.z  = (add_full[DW-1:0] == '0);
        flg_out.ov = (w_in[DW-1] == imm[DW-1]) && (add_full[DW-1] != w_in[DW-1]);
        flg_out.n  = add_full[DW-1];
      end
      OP_SUB: begin
        w_out      = sub_full[DW-1:0];
        w_wr       = 1'b1;
        flg_out.c  = sub_full[DW];
        flg_out.dc = sub_nib[NIB];
        flg_out.z  = (sub_full[DW-1:0] == '0);
        flg_out.ov = (imm[DW-1] != w_in[DW-1]) && (sub_full[DW-1] != imm[DW-1]);
        flg_out.n  = sub_full[DW-1];
      end
      OP_AND, OP_IOR, OP_XOR: begin
        w_out     = logic_res;
        w_wr      = 1'b1;
        flg_out.z = (logic_res == '0);
        flg_out.n = logic_res[DW-1];
      end
      OP_MOV, OP_RET: begin
        w_out = imm;
        w_wr  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lit_ptr_bank.sv
module lit_ptr_bank
  import lit_alu_pkg::*;
#(
  parameter int DW      = 8,
  parameter int PTR_W   = 12,
  parameter int NUM_PTR = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc,
  input  lit_op_e                  op,
  input  logic [DW-1:0]            imm,
  output logic [NUM_PTR*PTR_W-1:0] ptr_flat
);
  localparam int HI_W = PTR_W - DW;

  logic            pend_q, pend_d;
  logic [1:0]      sel_q, sel_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic            commit;

  // Any accepted word consumes a pending first word; only a new first word rearms it.
  always_comb begin
    pend_d = pend_q;
    sel_d  = sel_q;
    hi_d   = hi_q;
    if (acc) begin
      pend_d = (op == OP_PTRHI);
      if (op == OP_PTRHI) begin
        sel_d = imm[5:4];
        hi_d  = imm[HI_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sel_q  <= '0;
      hi_q   <= '0;
    end else begin
      pend_q <= pend_d;
      sel_q  <= sel_d;
      hi_q   <= hi_d;
    end
  end

  assign commit = acc && pend_q && (op == OP_PTRLO);

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic [PTR_W-1:0] p_q, p_d;
    logic             p_en;
    assign p_en = commit && (sel_q == g[1:0]);
    always_comb p_d = p_en ? {hi_q, imm} : p_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) p_q <= '0;
      else        p_q <= p_d;
    end
    assign ptr_flat[g*PTR_W +: PTR_W] = p_q;
  end

  // R9
  orphan_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_PTRLO && !pend_q) |=> $stable(ptr_flat));
  // R10
  reserved_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_PTRLO && pend_q && sel_q == 2'd3) |=> $stable(ptr_flat));
endmodule

// File: rtl/lit_exec_unit.sv
module lit_exec_unit
  import lit_alu_pkg::*;
#(
  parameter int DW      = 8,
  parameter int BANK_W  = 4,
  parameter int PTR_W   = 12,
  parameter int NUM_PTR = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     instr_valid,
  input  logic [15:0]              instr_word,
  output logic [DW-1:0]            w_q,
  output logic [BANK_W-1:0]        bank_q,
  output logic [2*DW-1:0]          prod_q,
  output logic [NUM_PTR*PTR_W-1:0] ptr_flat,
  output logic [4:0]               status_q,
  output logic                     stall,
  output logic                     ret_strobe
);
  lit_op_e         op;
  logic [DW-1:0]   imm, w_nx_alu;
  logic            w_wr, acc;
  flags_t          flg_q, flg_d, flg_alu;
  logic [DW-1:0]   w_d;
  logic [BANK_W-1:0] bank_d;
  logic [2*DW-1:0] prod_d, prod_alu;
  logic            flush_q, flush_d;

  lit_decode u_dec (.word(instr_word), .op(op), .imm(imm));

  lit_arith #(.DW(DW)) u_alu (
    .op(op), .w_in(w_q), .imm(imm), .flg_in(flg_q),
    .w_out(w_nx_alu), .w_wr(w_wr), .flg_out(flg_alu), .product(prod_alu)
  );

  lit_ptr_bank #(.DW(DW), .PTR_W(PTR_W), .NUM_PTR(NUM_PTR)) u_ptr (
    .clk(clk), .rst_n(rst_n), .acc(acc), .op(op), .imm(imm), .ptr_flat(ptr_flat)
  );

  assign acc        = instr_valid && !flush_q;
  assign ret_strobe = acc && (op == OP_RET);
  assign stall      = flush_q;
  assign status_q   = flg_q;

  always_comb begin
    w_d     = w_q;
    flg_d   = flg_q;
    bank_d  = bank_q;
    prod_d  = prod_q;
    flush_d = 1'b0;
    if (acc) begin
      if (w_wr) w_d = w_nx_alu;
      flg_d   = flg_alu;
      flush_d = (op == OP_RET);
      if (op == OP_BANK) bank_d = imm[BANK_W-1:0];
      if (op == OP_MUL)  prod_d = prod_alu;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q     <= '0;
      flg_q   <= '0;
      bank_q  <= '0;
      prod_q  <= '0;
      flush_q <= 1'b0;
    end else begin
      w_q     <= w_d;
      flg_q   <= flg_d;
      bank_q  <= bank_d;
      prod_q  <= prod_d;
      flush_q <= flush_d;
    end
  end

  // R11
  ret_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_strobe |=> stall);
  // R11
  single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(w_q) && $stable(status_q) && $stable(bank_q)));
  // R4
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == OP_AND || op == OP_IOR || op == OP_XOR))
      |=> (status_q[0] == $past(status_q[0]) && status_q[1] == $past(status_q[1])
           && status_q[3] == $past(status_q[3])));
  // R5
  mov_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == OP_MOV || op == OP_BANK || op == OP_PTRHI || op == OP_PTRLO))
      |=> $stable(status_q));
  // R6
  mul_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_MUL) |=> ($stable(w_q) && $stable(status_q)));
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid && !stall) |=> ($stable(w_q) && $stable(prod_q) && $stable(ptr_flat)));
endmodule

// File: tb/lit_exec_unit_bench.sv
module lit_exec_unit_bench;
  logic        clk, rst_n, instr_valid;
  logic [15:0] instr_word;
  logic [7:0]  w_q;
  logic [3:0]  bank_q;
  logic [15:0] prod_q;
  logic [35:0] ptr_flat;
  logic [4:0]  status_q;
  logic        stall, ret_strobe;
  int checks = 0, errors = 0;
  logic        seen_ret;

  lit_exec_unit u_lit_exec_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .w_q(w_q), .bank_q(bank_q), .prod_q(prod_q), .ptr_flat(ptr_flat),
    .status_q(status_q), .stall(stall), .ret_strobe(ret_strobe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs move 1 ns after an edge; outputs are read 1 ns after the following edge.
  task automatic step(input logic v, input logic [15:0] w);
    instr_valid = v;
    instr_word  = w;
    #2;
    seen_ret = ret_strobe;
    @(posedge clk);
    #1;
    instr_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 w", w_q, 0); chk("R1 status", status_q, 0);
    chk("R1 ptr", ptr_flat, 0); chk("R1 prod", prod_q, 0);
    chk("R1 bank", bank_q, 0); chk("R1 stall", stall, 0);
  endtask

  task automatic t_add;
    step(1, 16'h0E7F); chk("R5 mov", w_q, 8'h7F); chk("R5 flags", status_q, 0);
    step(1, 16'h0F01); chk("R2 sum", w_q, 8'h80); chk("R2 flags ov", status_q, 5'h1A);
    step(1, 16'h0F80); chk("R2 wrap", w_q, 8'h00); chk("R2 flags zc", status_q, 5'h0D);
  endtask

  task automatic t_sub;
    step(1, 16'h0E05); chk("R5 flags kept", status_q, 5'h0D);
    step(1, 16'h0803); chk("R3 borrow", w_q, 8'hFE); chk("R3 flags b", status_q, 5'h10);
    step(1, 16'h0E03);
    step(1, 16'h0810); chk("R3 nib", w_q, 8'h0D); chk("R3 flags nib", status_q, 5'h01);
    step(1, 16'h0E22);
    step(1, 16'h0822); chk("R3 eq", w_q, 8'h00); chk("R3 flags eq", status_q, 5'h07);
    step(1, 16'h0E01);
    step(1, 16'h0880); chk("R3 ov", w_q, 8'h7F); chk("R3 flags ov", status_q, 5'h09);
  endtask

  task automatic t_logic;
    step(1, 16'h0EF0);
    step(1, 16'h0B0F); chk("R4 and", w_q, 8'h00); chk("R4 and flags", status_q, 5'h0D);
    step(1, 16'h0981); chk("R4 ior", w_q, 8'h81); chk("R4 ior flags", status_q, 5'h19);
    step(1, 16'h0A81); chk("R4 xor", w_q, 8'h00); chk("R4 xor flags", status_q, 5'h0D);
  endtask

  task automatic t_mul_bank;
    step(1, 16'h0EFF);
    step(1, 16'h0DFF); chk("R6 prod", prod_q, 16'hFE01);
    chk("R6 w", w_q, 8'hFF); chk("R6 flags", status_q, 5'h0D);
    step(1, 16'h0105); chk("R7 bank", bank_q, 4'h5);
    step(1, 16'h0113); chk("R7 bad form", bank_q, 4'h5);
  endtask

  task automatic t_ptr;
    step(1, 16'hEE1A); step(1, 16'hF0BC);
    chk("R8 ptr1", ptr_flat, {12'h000, 12'hABC, 12'h000});
    step(1, 16'hEE03); step(1, 16'hF044);
    chk("R8 ptr0", ptr_flat, {12'h000, 12'hABC, 12'h344});
    chk("R8 flags", status_q, 5'h0D);
    step(1, 16'hEE3F); step(1, 16'hF011);
    chk("R10 reserved", ptr_flat, {12'h000, 12'hABC, 12'h344});
    step(1, 16'hF055);
    chk("R9 orphan ptr", ptr_flat, {12'h000, 12'hABC, 12'h344});
    chk("R9 orphan w", w_q, 8'hFF);
    step(1, 16'hEE27); step(1, 16'h0E66); step(1, 16'hF099);
    chk("R8 abandon w", w_q, 8'h66);
    chk("R8 abandon ptr", ptr_flat, {12'h000, 12'hABC, 12'h344});
  endtask

  task automatic t_ret;
    step(1, 16'h0C42);
    chk("R11 strobe", seen_ret, 1); chk("R11 w", w_q, 8'h42); chk("R11 stall", stall, 1);
    step(1, 16'h0E99);
    chk("R11 strobe in stall", seen_ret, 0);
    chk("R11 ignored", w_q, 8'h42); chk("R11 stall drop", stall, 0);
    step(0, 16'h0E77); chk("R1 idle", w_q, 8'h42);
  endtask

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0; seen_ret = 1'b0;
    #23 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset; t_add; t_sub; t_logic; t_mul_bank; t_ptr; t_ret;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule